// File: doc/BRIEF.md
# Single-Wire Bit Token Codec

This block sits between a host that works in bytes and a half-duplex UART that drives a single-wire bus to a secure element. On that bus every data bit travels as a whole 7-bit UART character. A 0 bit is the character 0x7D and a 1 bit is 0x7F. On transmit the codec turns each host byte into eight such characters, least significant bit first. On receive it classifies every character it gets as a 0 or 1 token and packs each run of eight tokens back into a byte.

The host issues one request at a time through a valid/ready handshake. A request carries a kind: a plain data byte, a wake, or one of four bus-direction flags. A wake is a single raw 0x00 character followed by a programmable hold-off. A flag is one token-encoded byte.

The "device may transmit" flag also turns the line around. The codec ignores its own echoed characters for a guard interval and then collects the reply. The reply ends when the line stays silent for a set number of bit periods. At that point the codec raises an end-of-burst strobe, drops any partial group of tokens and becomes ready for the next request.

Top module: `bitwire_token_codec`

## Requirements
- R1: Every line character is either a token or the raw wake character. A 0 bit is sent as 0x7D and a 1 bit as 0x7F, eight characters per byte, bit 0 first. Request kinds 0 and 3 both send `req_byte` as data.
- R2: Request kind 2 sends a flag byte chosen by `req_byte[1:0]`, token-encoded as in R1. The codes are 0 → 0x77 (command follows), 1 → 0x88 (device may transmit), 2 → 0xBB (idle) and 3 → 0xCC (sleep).
- R3: Request kind 1 sends one raw 0x00 character. After that character's handshake, `req_ready` stays low for HOLD cycles, where HOLD = (CLK_HZ/1000)·WAKE_US/1000.
- R4: While `lt_valid` is high and `lt_ready` is low, `lt_valid` stays high and `lt_char` holds its value.
- R5: A received character decodes as 1 when bits 6..1 of `lr_char` are all one, and as 0 otherwise. Bit 7 and bit 0 do not affect the result.
- R6: Tokens are packed bit 0 first. `byte_done` pulses, with the byte on `rx_byte`, in the cycle after the cycle that presents the eighth token of a group.
- R7: Characters are taken only in the listen window. That window opens GUARD_BITS bit periods after the last 0x88 token is handed to the UART. Characters at any other time produce no byte.
- R8: In the listen window, `end_of_burst` pulses for one cycle IDLE_BITS·(CLK_HZ/BAUD) cycles after the cycle of the last received character. Any fewer than eight leftover tokens are discarded, and `req_ready` returns high.
- R9: A character that arrives in the cycle where the silence timeout would expire wins. No `end_of_burst` is raised, the token is counted and the burst continues.
- R10: After reset, `req_ready` is 1 and `lt_valid`, `byte_done` and `end_of_burst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Codec idle and able to take a request |
| req_kind | input | 2 | 0/3 data, 1 wake, 2 direction flag |
| req_byte | input | 8 | Data byte, or flag select in bits 1..0 |
| lt_valid | output | 1 | Character for the UART transmitter is valid |
| lt_ready | input | 1 | UART transmitter takes the character |
| lt_char | output | 8 | Character to transmit |
| lr_valid | input | 1 | UART receiver presents a character (one cycle) |
| lr_char | input | 8 | Received character |
| rx_byte | output | 8 | Last packed receive byte |
| byte_done | output | 1 | One-cycle strobe: `rx_byte` updated |
| end_of_burst | output | 1 | One-cycle strobe: receive burst ended |

## Verification
The silence timeout and the arrival of a new token can fall in the same cycle. The bench provokes this by counting cycles from the last token of a byte and presenting the next token exactly in the cycle where the timeout would fire. The test passes when only one end-of-burst is seen for the whole burst, both bytes arrive intact, and the final timeout is measured from the late token. A second overlap, where echo characters arrive while the guard window is still open, is judged by the number and values of the bytes received.

// File: rtl/bwt_pkg.sv
`timescale 1ns/1ps
package bwt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_HOLD,
    S_GUARD,
    S_LISTEN
  } seq_state_t;

  localparam logic [1:0] KIND_WAKE = 2'd1;
  localparam logic [1:0] KIND_FLAG = 2'd2;
  localparam logic [1:0] FLAG_TURN = 2'd1;

  // line character carrying one data bit
  function automatic logic [7:0] tok_char(input logic b);
    return 8'h7D | {6'd0, b, 1'b0};
  endfunction

  // tolerant decode: bits 6..1 all set means a 1 token
  function automatic logic tok_value(input logic [7:0] c);
    return &c[6:1];
  endfunction

  function automatic logic [7:0] flag_code(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h77;
      2'd1:    return 8'h88;
      2'd2:    return 8'hBB;
      default: return 8'hCC;
    endcase
  endfunction

endpackage

// File: rtl/bwt_serializer.sv
`timescale 1ns/1ps
module bwt_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         load_raw,
  input  logic [W-1:0] load_byte,
  input  logic         lt_ready,
  output logic         lt_valid,
  output logic [7:0]   lt_char,
  output logic         last_fire
);
  import bwt_pkg::*;

  localparam int IDXW = (W > 1) ? $clog2(W) : 1;

  logic            busy;
  logic            raw;
  logic [W-1:0]    sh;
  logic [IDXW-1:0] idx;
  logic            fire;

  assign lt_valid  = busy;
  assign lt_char   = raw ? 8'h00 : tok_char(sh[0]);
  assign fire      = busy & lt_ready;
  assign last_fire = fire & (raw | (idx == IDXW'(W-1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      raw  <= 1'b0;
      sh   <= '0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      raw  <= load_raw;
      sh   <= load_byte;
      idx  <= '0;
    end else if (fire) begin
      if (last_fire) begin
        busy <= 1'b0;
      end else begin
        sh  <= sh >> 1;
        idx <= idx + 1'b1;
      end
    end
  end

  // R4: a stalled character is held
  p_char_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_valid && !lt_ready) |=> (lt_valid && $stable(lt_char)));

endmodule

// File: rtl/bwt_packer.sv
`timescale 1ns/1ps
module bwt_packer #(
  parameter int W        = 8,
  parameter int IDLE_CYC = 240
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         lr_valid,
  input  logic [7:0]   lr_char,
  output logic [W-1:0] rx_byte,
  output logic         byte_done,
  output logic         end_of_burst
);
  import bwt_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int TW = $clog2(IDLE_CYC + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic [TW-1:0] quiet;
  logic          tok_in;
  logic          tok_bit;
  logic [W-1:0]  next_sh;

  assign tok_in       = en & lr_valid;
  assign tok_bit      = tok_value(lr_char);
  assign next_sh      = {tok_bit, sh[W-1:1]};
  assign end_of_burst = en & ~lr_valid & (quiet == TW'(IDLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      quiet     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (clr) begin
        cnt   <= '0;
        quiet <= '0;
      end else if (tok_in) begin
        quiet <= '0;
        sh    <= next_sh;
        if (cnt == CW'(W-1)) begin
          cnt       <= '0;
          rx_byte   <= next_sh;
          byte_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (end_of_burst) begin
        cnt <= '0;
      end else if (en) begin
        quiet <= quiet + 1'b1;
      end
    end
  end

  // R8: the end strobe is a single-cycle pulse
  p_eob_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_burst |=> !end_of_burst);

  // R7: bytes only come from tokens taken in the listen window
  p_byte_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(en));

endmodule

// File: rtl/bitwire_token_codec.sv
`timescale 1ns/1ps
module bitwire_token_codec #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int BAUD       = 230_400,
  parameter int IDLE_BITS  = 24,
  parameter int GUARD_BITS = 12,
  parameter int WAKE_US    = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic [7:0] req_byte,
  output logic       lt_valid,
  input  logic       lt_ready,
  output logic [7:0] lt_char,
  input  logic       lr_valid,
  input  logic [7:0] lr_char,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       end_of_burst
);
  import bwt_pkg::*;

  localparam int BIT_CYC   = CLK_HZ / BAUD;
  localparam int IDLE_CYC  = IDLE_BITS * BIT_CYC;
  localparam int GUARD_CYC = GUARD_BITS * BIT_CYC;
  localparam int HOLD_CYC  = (CLK_HZ / 1000) * WAKE_US / 1000;
  localparam int TMR_MAX   = (HOLD_CYC > GUARD_CYC) ? HOLD_CYC : GUARD_CYC;
  localparam int TMRW      = $clog2(TMR_MAX + 1);

  seq_state_t      state;
  logic [TMRW-1:0] tmr;
  logic            pend_wake;
  logic            pend_turn;
  logic            accept;
  logic            is_wake;
  logic            is_flag;
  logic [7:0]      load_byte;
  logic            ser_last;
  logic            listen_clr;
  logic            listen_en;
  logic            hold_end;
  logic            guard_end;

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_valid & req_ready;
  assign is_wake    = (req_kind == KIND_WAKE);
  assign is_flag    = (req_kind == KIND_FLAG);
  assign load_byte  = is_flag ? flag_code(req_byte[1:0]) : req_byte;
  assign hold_end   = (state == S_HOLD)  && (tmr == TMRW'(HOLD_CYC - 1));
  assign guard_end  = (state == S_GUARD) && (tmr == TMRW'(GUARD_CYC - 1));
  assign listen_clr = guard_end;
  assign listen_en  = (state == S_LISTEN);

  bwt_serializer #(.W(8)) ser_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_raw  (is_wake),
    .load_byte (load_byte),
    .lt_ready  (lt_ready),
    .lt_valid  (lt_valid),
    .lt_char   (lt_char),
    .last_fire (ser_last)
  );

  bwt_packer #(.W(8), .IDLE_CYC(IDLE_CYC)) pack_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (listen_en),
    .clr          (listen_clr),
    .lr_valid     (lr_valid),
    .lr_char      (lr_char),
    .rx_byte      (rx_byte),
    .byte_done    (byte_done),
    .end_of_burst (end_of_burst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tmr       <= '0;
      pend_wake <= 1'b0;
      pend_turn <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state     <= S_SEND;
          pend_wake <= is_wake;
          pend_turn <= is_flag & (req_byte[1:0] == FLAG_TURN);
        end
        S_SEND: if (ser_last) begin
          tmr <= '0;
          if (pend_wake)      state <= S_HOLD;
          else if (pend_turn) state <= S_GUARD;
          else                state <= S_IDLE;
        end
        S_HOLD: begin
          tmr <= tmr + 1'b1;
          if (hold_end) state <= S_IDLE;
        end
        S_GUARD: begin
          tmr <= tmr + 1'b1;
          if (guard_end) state <= S_LISTEN;
        end
        S_LISTEN: if (end_of_burst) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: only token characters or the raw wake character reach the line
  p_line_alphabet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lt_valid |-> (lt_char == 8'h7D || lt_char == 8'h7F || lt_char == 8'h00));

  // R3: the line stays quiet during the wake hold-off
  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> !lt_valid);

  // R7: no transmit while the reply is being collected
  p_listen_no_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LISTEN) |-> !lt_valid);

endmodule

// File: tb/bitwire_token_codec_tb.sv
`timescale 1ns/1ps
module bitwire_token_codec_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int P_CLK_HZ   = 2_304_000;
  localparam int P_BAUD     = 230_400;
  localparam int P_IDLE     = 24;
  localparam int P_GUARD    = 12;
  localparam int P_WAKE_US  = 100;
  localparam int BITC       = P_CLK_HZ / P_BAUD;
  localparam int IDLE_C     = P_IDLE * BITC;
  localparam int GUARD_C    = P_GUARD * BITC;
  localparam longint HOLD_L = (longint'(P_WAKE_US) * P_CLK_HZ) / 1_000_000;
  localparam int HOLD_C     = int'(HOLD_L);

  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0;
  logic       req_ready;
  logic [1:0] req_kind = 0;
  logic [7:0] req_byte = 0;
  logic       lt_valid;
  logic       lt_ready = 0;
  logic [7:0] lt_char;
  logic       lr_valid = 0;
  logic [7:0] lr_char = 0;
  logic [7:0] rx_byte;
  logic       byte_done;
  logic       end_of_burst;

  bitwire_token_codec #(
    .CLK_HZ(P_CLK_HZ), .BAUD(P_BAUD), .IDLE_BITS(P_IDLE),
    .GUARD_BITS(P_GUARD), .WAKE_US(P_WAKE_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte), .lt_valid(lt_valid),
    .lt_ready(lt_ready), .lt_char(lt_char), .lr_valid(lr_valid),
    .lr_char(lr_char), .rx_byte(rx_byte), .byte_done(byte_done),
    .end_of_burst(end_of_burst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] expq[$];
  logic [7:0] gotq[$];
  int eob_n = 0;
  int eob_cyc = 0;
  int last_tx_cyc = 0;
  int raw_cyc = 0;
  int last_char_cyc = 0;
  logic prev_stall = 0;
  logic [7:0] prev_char = 0;
  logic done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bench restatement of the line alphabet
  function automatic logic [7:0] exp_tok(input logic [7:0] b, input int i);
    return b[i] ? 8'h7F : 8'h7D;
  endfunction

  function automatic logic [7:0] exp_flag(input int s);
    logic [7:0] t [4] = '{8'h77, 8'h88, 8'hBB, 8'hCC};
    return t[s];
  endfunction

  // random line character that must decode to v
  function automatic logic [7:0] rand_tok(input logic v);
    logic [7:0] r;
    r = 8'($urandom);
    if (v) r = r | 8'h7E;
    else if ((r & 8'h7E) == 8'h7E) r[3] = 1'b0;
    return r;
  endfunction

  // UART transmitter model
  always @(posedge clk) begin
    #1;
    lt_ready = rst_n && (($urandom % 4) != 0);
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(lt_valid && lt_char == prev_char, "R4 held char", int'(lt_char), int'(prev_char));
      prev_stall = lt_valid && !lt_ready;
      prev_char  = lt_char;
      if (lt_valid && lt_ready) begin
        last_tx_cyc = cyc;
        if (lt_char == 8'h00) raw_cyc = cyc;
        if (expq.size() == 0) chk(1'b0, "R1 unexpected char", int'(lt_char), 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(lt_char == e, "R1/R2 line char", int'(lt_char), int'(e));
        end
      end
      if (byte_done) gotq.push_back(rx_byte);
      if (end_of_burst) begin
        eob_n++;
        eob_cyc = cyc;
      end
    end
  end

  task automatic send_req(input logic [1:0] k, input logic [7:0] b);
    @(posedge clk); #1;
    req_valid = 1; req_kind = k; req_byte = b;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_tx_empty();
    while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c, input int gap);
    @(posedge clk); #1;
    lr_valid = 1; lr_char = c; last_char_cyc = cyc;
    @(posedge clk); #1;
    lr_valid = 0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic send_tok_byte(input logic [7:0] b, input int gap);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      lr_valid = 1; lr_char = rand_tok(b[i]); last_char_cyc = cyc;
      if (i == 7) begin
        @(negedge clk);
        chk(!byte_done, "R6 byte_done early", int'(byte_done), 0);
      end
      @(posedge clk); #1;
      lr_valid = 0;
      if (i == 7) begin
        @(negedge clk);
        chk(byte_done && rx_byte == b, "R5/R6 packed byte", int'(rx_byte), int'(b));
      end
      if (i != 7) repeat ($urandom % 6) @(posedge clk);
    end
    repeat (gap) @(posedge clk);
  endtask

  task automatic burst(input int nbytes, input int extra, input logic collide);
    logic [7:0] exp_b[$];
    int e0;
    for (int i = 0; i < 8; i++) expq.push_back(exp_tok(8'h88, i));
    send_req(2'd2, 8'd1);
    wait_tx_empty();
    repeat (3) send_char(8'h7F, 1);  // echo during guard: ignored (R7)
    while (cyc - last_tx_cyc < GUARD_C + 6) @(posedge clk);
    gotq.delete();
    e0 = eob_n;
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_b.push_back(b);
      send_tok_byte(b, 0);
      if (collide && i == 0) begin
        // next token lands in the cycle the timeout would expire (R9)
        while (cyc != last_char_cyc + IDLE_C - 1) begin
          @(posedge clk); #1;
        end
      end else begin
        repeat ($urandom % 20) @(posedge clk);
      end
    end
    for (int i = 0; i < extra; i++) send_char(rand_tok(1'($urandom)), 2);
    while (eob_n == e0) @(negedge clk);
    chk(gotq.size() == nbytes, "R7/R8 byte count", gotq.size(), nbytes);
    for (int i = 0; i < nbytes && i < gotq.size(); i++)
      chk(gotq[i] == exp_b[i], "R6 burst byte", int'(gotq[i]), int'(exp_b[i]));
    if (nbytes + extra > 0)
      chk(eob_cyc - last_char_cyc == IDLE_C, "R8/R9 timeout cycle", eob_cyc - last_char_cyc, IDLE_C);
    @(negedge clk);
    chk(eob_n == e0 + 1, "R9 single end strobe", eob_n - e0, 1);
    chk(req_ready, "R8 ready after burst", int'(req_ready), 1);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1, "R10 reset ready", int'(req_ready), 1);
    chk(lt_valid == 0, "R10 reset lt_valid", int'(lt_valid), 0);
    chk(byte_done == 0, "R10 reset byte_done", int'(byte_done), 0);
    chk(end_of_burst == 0, "R10 reset eob", int'(end_of_burst), 0);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // R7: characters while idle produce nothing
    for (int i = 0; i < 8; i++) send_char(8'h7F, 1);
    repeat (5) @(posedge clk);
    chk(gotq.size() == 0, "R7 idle chars ignored", gotq.size(), 0);

    // R1: random data bytes, kinds 0 and 3, plus directed corners
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      logic [1:0] k;
      b = (n == 0) ? 8'h00 : (n == 1) ? 8'hFF : (n == 2) ? 8'h01 : 8'($urandom);
      k = (n % 3 == 0) ? 2'd3 : 2'd0;
      for (int i = 0; i < 8; i++) expq.push_back(exp_tok(b, i));
      send_req(k, b);
    end
    wait_tx_empty();

    // R2: non-turnaround flags
    for (int s = 0; s < 4; s++) begin
      if (s != 1) begin
        for (int i = 0; i < 8; i++) expq.push_back(exp_tok(exp_flag(s), i));
        send_req(2'd2, {6'($urandom), 2'(s)});
      end
    end
    wait_tx_empty();

    // R3: wake raw character and hold-off
    for (int w = 0; w < 2; w++) begin
      expq.push_back(8'h00);
      send_req(2'd1, 8'($urandom));
      do @(negedge clk); while (!req_ready);
      chk(cyc - raw_cyc == HOLD_C + 1, "R3 wake hold-off", cyc - raw_cyc, HOLD_C + 1);
    end

    // R5..R9: receive bursts
    burst(3, 0, 1'b0);
    burst(2, 5, 1'b0);   // partial trailing tokens discarded
    burst(1, 0, 1'b0);
    burst(0, 0, 1'b0);
    burst(2, 0, 1'b1);   // token meets the timeout cycle
    burst(1, 3, 1'b1);

    repeat (5) @(posedge clk);
    chk(expq.size() == 0, "R1 all chars sent", expq.size(), 0);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule